// File: doc/BRIEF.md
# USB Endpoint Stall and Data-Toggle Controller

This block holds the control state of one direction of a USB device endpoint and turns each received data packet into a handshake decision. Software programs a small control word through a simple write strobe and reads it back at any time. The word carries an enable bit, a two-bit transfer kind, a stall request, a toggle-sequence reset strobe and a test-only toggle bypass. The packet engine reports SETUP arrivals, the level of the endpoint's setup-pending flag, and the data PID of every received data packet.

One cycle after each packet the block answers with one of four codes. STALL means the endpoint is halted. REFUSE means the endpoint is switched off. ACCEPT means the data is taken. DISCARD means the packet is acknowledged but its data is dropped because the PID repeats the previous one. The block also keeps the DATA0/DATA1 value it expects next.

On control endpoints a SETUP arrival lifts the stall. The stall then stays forced clear while the setup-pending flag is high, and for a parameterised number of clocks (at most 50) after the flag drops. A stall request written during that window is lost.

Top module: `usbep_stall_toggle_ctrl`

## Requirements
- R1: Writing 1 to control bit 0 sets the stall. While the stall is set, every packet is answered with code 1 (STALL). Writing 0 to bit 0 clears it.
- R2: When the kind field holds 0 (control) and `setup_seen` pulses, the stall reads 0 after the next clock edge. For any other kind, a SETUP leaves the stall unchanged.
- R3: For a control endpoint, a write of 1 to the stall bit is lost while `setup_stat` is high.
- R4: After `setup_stat` is first sampled low, stall writes are still lost on the next HOLDOFF_CYC clock edges, counting that edge. A write on the following edge takes effect.
- R5: Bits [3:2] hold the transfer kind: 0 control, 1 isochronous, 2 bulk, 3 interrupt. The field reads back as written.
- R6: Bit 6 is the enable and resets to 0. While it is 0 and the stall is clear, every packet gets code 3 (REFUSE) and the expected toggle does not change.
- R7: Writing 1 to bit 5 sets the expected PID to DATA0 (`exp_pid` = 0). Bit 5 always reads 0.
- R8: Bit 1 is the toggle bypass and resets to 0. When it is 1, an enabled, unstalled endpoint accepts every packet (code 0) and keeps its expected toggle.
- R9: Bit 4 always reads 0, even right after a 1 is written to it.
- R10: With the bypass off and a kind other than isochronous, a packet whose PID equals `exp_pid` gets code 0 (ACCEPT) and flips `exp_pid`. A packet with the other PID gets code 2 (DISCARD) and leaves `exp_pid` unchanged.
- R11: An enabled, unstalled isochronous endpoint accepts every packet with code 0 and never changes `exp_pid`.
- R12: A SETUP on a control endpoint sets `exp_pid` to 1 (DATA1).
- R13: After reset the control word reads 0, `exp_pid` is 0 and `rsp_valid` is 0. `rsp_valid` pulses exactly one clock after each `pkt_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_wr | input | 1 | Write strobe for the control word |
| csr_wdata | input | CSR_W | Control word write data |
| csr_rdata | output | CSR_W | Control word read data |
| setup_seen | input | 1 | One-cycle pulse: a SETUP arrived for this endpoint |
| setup_stat | input | 1 | Setup-pending flag level |
| pkt_valid | input | 1 | One-cycle pulse: a data packet was received |
| pkt_pid | input | 1 | Data PID of that packet, 0 = DATA0, 1 = DATA1 |
| rsp_valid | output | 1 | Handshake decision is valid |
| rsp_code | output | 2 | 0 ACCEPT, 1 STALL, 2 DISCARD, 3 REFUSE |
| stall_active | output | 1 | Current stall state |
| exp_pid | output | 1 | Next expected data PID |

## Verification
Control-word writes, stall changes and toggle changes all become visible one clock edge after the strobe. The bench drives each stimulus on a falling edge and reads back on the next falling edge. The handshake code is registered, so it is sampled on the falling edge that follows the single rising edge on which `pkt_valid` was high. The holdoff window is counted in rising edges from the first edge that sees `setup_stat` low. The bench places one write on the last blocked edge and one on the first free edge, and checks the stall after each of them.

// File: rtl/usbep_pkg.sv
package usbep_pkg;
   typedef enum logic [1:0] {
      EP_CTRL = 2'd0,
      EP_ISO  = 2'd1,
      EP_BULK = 2'd2,
      EP_INTR = 2'd3
   } ep_kind_e;

   typedef enum logic [1:0] {
      RSP_ACCEPT  = 2'd0,
      RSP_STALL   = 2'd1,
      RSP_DISCARD = 2'd2,
      RSP_REFUSE  = 2'd3
   } ep_rsp_e;

   localparam int unsigned F_STALL   = 0;
   localparam int unsigned F_BYPASS  = 1;
   localparam int unsigned F_KIND_LO = 2;
   localparam int unsigned F_SINK    = 4;
   localparam int unsigned F_TRST    = 5;
   localparam int unsigned F_ENABLE  = 6;
   localparam int unsigned CSR_MIN_W = 7;
   localparam int unsigned HOLDOFF_LIMIT = 50;
endpackage

// File: rtl/usbep_holdoff.sv
module usbep_holdoff #(
   parameter int unsigned CYCLES = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic hold
);
   generate
      if (CYCLES == 0) begin : g_none
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign hold = arm;
      end else begin : g_cnt
         localparam int unsigned CW = $clog2(CYCLES + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (arm)        cnt <= CW'(CYCLES);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end
         assign hold = arm || (cnt != '0);

         assert_hold_after_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(arm) |-> hold);
      end
   endgenerate
endmodule

// File: rtl/usbep_ctrl_reg.sv
module usbep_ctrl_reg
   import usbep_pkg::*;
#(
   parameter int unsigned CSR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CSR_W-1:0] wdata,
   input  logic             setup_seen,
   input  logic             hold,
   output logic [CSR_W-1:0] rdata,
   output logic             stall,
   output logic             enable,
   output logic             bypass,
   output ep_kind_e         kind,
   output logic             trst
);
   logic is_ctrl;
   logic unused_wbits;

   assign is_ctrl      = (kind == EP_CTRL);
   assign trst         = wr && wdata[F_TRST];
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= 1'b0;
         bypass <= 1'b0;
         kind   <= EP_CTRL;
      end else if (wr) begin
         enable <= wdata[F_ENABLE];
         bypass <= wdata[F_BYPASS];
         kind   <= ep_kind_e'(wdata[F_KIND_LO +: 2]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              stall <= 1'b0;
      else if ((setup_seen && is_ctrl) || hold) stall <= 1'b0;
      else if (wr)                             stall <= wdata[F_STALL];
   end

   always_comb begin
      rdata                    = '0;
      rdata[F_STALL]           = stall;
      rdata[F_BYPASS]          = bypass;
      rdata[F_KIND_LO +: 2]    = kind;
      rdata[F_ENABLE]          = enable;
   end

   assert_setup_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_seen && is_ctrl) |=> !stall);
   assert_hold_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !stall);
   assert_sink_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[F_SINK] == 1'b0 && rdata[F_TRST] == 1'b0);
endmodule

// File: rtl/usbep_toggle.sv
module usbep_toggle
   import usbep_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     trst,
   input  logic     setup_seen,
   input  ep_kind_e kind,
   input  logic     stall,
   input  logic     enable,
   input  logic     bypass,
   input  logic     pkt_valid,
   input  logic     pkt_pid,
   output logic     exp_tog,
   output logic     rsp_valid,
   output ep_rsp_e  rsp
);
   ep_rsp_e rsp_d;
   logic    adv;

   always_comb begin
      adv = 1'b0;
      if (stall)                              rsp_d = RSP_STALL;
      else if (!enable)                       rsp_d = RSP_REFUSE;
      else if (bypass || kind == EP_ISO)      rsp_d = RSP_ACCEPT;
      else if (pkt_pid == exp_tog) begin
         rsp_d = RSP_ACCEPT;
         adv   = 1'b1;
      end else                                rsp_d = RSP_DISCARD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              exp_tog <= 1'b0;
      else if (trst)                           exp_tog <= 1'b0;
      else if (setup_seen && kind == EP_CTRL)  exp_tog <= 1'b1;
      else if (pkt_valid && adv)               exp_tog <= ~exp_tog;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp       <= RSP_ACCEPT;
      end else begin
         rsp_valid <= pkt_valid;
         if (pkt_valid) rsp <= rsp_d;
      end
   end

   assert_stall_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && stall) |=> (rsp_valid && rsp == RSP_STALL));
   assert_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !stall && !enable) |=> (rsp == RSP_REFUSE));
   assert_tgl_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trst |=> !exp_tog);
   assert_iso_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && kind == EP_ISO && !trst) |=> $stable(exp_tog));
   assert_setup_data1_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_seen && kind == EP_CTRL && !trst) |=> exp_tog);
   assert_rsp_timing_R13: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |=> rsp_valid);
endmodule

// File: rtl/usbep_stall_toggle_ctrl.sv
module usbep_stall_toggle_ctrl
   import usbep_pkg::*;
#(
   parameter int unsigned CSR_W       = 8,
   parameter int unsigned HOLDOFF_CYC = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csr_wr,
   input  logic [CSR_W-1:0] csr_wdata,
   output logic [CSR_W-1:0] csr_rdata,
   input  logic             setup_seen,
   input  logic             setup_stat,
   input  logic             pkt_valid,
   input  logic             pkt_pid,
   output logic             rsp_valid,
   output logic [1:0]       rsp_code,
   output logic             stall_active,
   output logic             exp_pid
);
   generate
      if (HOLDOFF_CYC > HOLDOFF_LIMIT) begin : g_bad_holdoff
         $error("HOLDOFF_CYC exceeds the 50-clock limit");
      end
      if (CSR_W < CSR_MIN_W) begin : g_bad_width
         $error("CSR_W too narrow for the control fields");
      end
   endgenerate

   logic     stall, enable, bypass, trst, hold;
   ep_kind_e kind;
   ep_rsp_e  rsp;

   usbep_holdoff #(.CYCLES(HOLDOFF_CYC)) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .arm  (setup_stat && kind == EP_CTRL),
      .hold (hold)
   );

   usbep_ctrl_reg #(.CSR_W(CSR_W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (csr_wr),
      .wdata     (csr_wdata),
      .setup_seen(setup_seen),
      .hold      (hold),
      .rdata     (csr_rdata),
      .stall     (stall),
      .enable    (enable),
      .bypass    (bypass),
      .kind      (kind),
      .trst      (trst)
   );

   usbep_toggle u_tgl (
      .clk       (clk),
      .rst_n     (rst_n),
      .trst      (trst),
      .setup_seen(setup_seen),
      .kind      (kind),
      .stall     (stall),
      .enable    (enable),
      .bypass    (bypass),
      .pkt_valid (pkt_valid),
      .pkt_pid   (pkt_pid),
      .exp_tog   (exp_pid),
      .rsp_valid (rsp_valid),
      .rsp       (rsp)
   );

   assign rsp_code     = rsp;
   assign stall_active = stall;
endmodule

// File: tb/tb_usbep_stall_toggle_ctrl.sv
`timescale 1ns/1ps
module tb_usbep_stall_toggle_ctrl;
   localparam int CW = 8;
   localparam int HO = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          csr_wr = 1'b0;
   logic [CW-1:0] csr_wdata = '0;
   logic [CW-1:0] csr_rdata;
   logic          setup_seen = 1'b0, setup_stat = 1'b0;
   logic          pkt_valid = 1'b0, pkt_pid = 1'b0;
   logic          rsp_valid, stall_active, exp_pid;
   logic [1:0]    rsp_code;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   usbep_stall_toggle_ctrl #(.CSR_W(CW), .HOLDOFF_CYC(HO)) dut (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .setup_seen(setup_seen), .setup_stat(setup_stat),
      .pkt_valid(pkt_valid), .pkt_pid(pkt_pid), .rsp_valid(rsp_valid),
      .rsp_code(rsp_code), .stall_active(stall_active), .exp_pid(exp_pid));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_csr(input logic [CW-1:0] d);
      csr_wr = 1'b1; csr_wdata = d;
      @(negedge clk);
      csr_wr = 1'b0; csr_wdata = '0;
   endtask

   task automatic send(input logic pid);
      pkt_valid = 1'b1; pkt_pid = pid;
      @(negedge clk);
      pkt_valid = 1'b0;
   endtask

   task automatic pulse_setup();
      setup_seen = 1'b1;
      @(negedge clk);
      setup_seen = 1'b0;
   endtask

   function automatic logic [CW-1:0] word(input bit en, input int kind, input bit byp,
                                          input bit st, input bit trst);
      return CW'((int'(en) << 6) | (int'(trst) << 5) | (kind << 2) | (int'(byp) << 1) | int'(st));
   endfunction

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         chk(1'b0, "WATCHDOG", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int e_tog, e_rsp;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk(csr_rdata == 0, "R13 rdata", csr_rdata, 0);
      chk(exp_pid == 0,   "R13 exp_pid", exp_pid, 0);
      chk(rsp_valid == 0, "R13 rsp_valid", rsp_valid, 0);
      // R6 enable resets low: packet refused
      send(1'b0);
      chk(rsp_code == 3 && rsp_valid, "R6 refuse after reset", rsp_code, 3);
      @(negedge clk);
      chk(rsp_valid == 0, "R13 single pulse", rsp_valid, 0);

      // R9 sink bit, R7 toggle reset bit reads 0
      wr_csr(8'h10);
      chk(csr_rdata == 0, "R9 sink reads 0", csr_rdata, 0);
      wr_csr(8'h20);
      chk(csr_rdata == 0, "R7 trst reads 0", csr_rdata, 0);

      // R5 kind field
      for (int k = 0; k < 4; k++) begin
         wr_csr(word(1, k, 0, 0, 0));
         chk(csr_rdata == word(1, k, 0, 0, 0), "R5 kind readback", csr_rdata, word(1, k, 0, 0, 0));
      end

      // Sweep kind x bypass x enable with PID patterns (R6 R8 R10 R11)
      for (int k = 0; k < 4; k++)
         for (int b = 0; b < 2; b++)
            for (int en = 0; en < 2; en++) begin
               wr_csr(word(en[0], k, b[0], 0, 1));
               e_tog = 0;
               chk(exp_pid == 0, "R7 trst to DATA0", exp_pid, 0);
               for (int p = 0; p < 6; p++) begin
                  logic pid;
                  pid = (6'b100110 >> p) & 1;
                  if (!en)            e_rsp = 3;
                  else if (b || k == 1) e_rsp = 0;
                  else if (pid == e_tog[0]) begin e_rsp = 0; e_tog ^= 1; end
                  else                e_rsp = 2;
                  send(pid);
                  if (!en)           chk(rsp_code == e_rsp, "R6 refuse", rsp_code, e_rsp);
                  else if (b)        chk(rsp_code == e_rsp, "R8 bypass", rsp_code, e_rsp);
                  else if (k == 1)   chk(rsp_code == e_rsp, "R11 iso", rsp_code, e_rsp);
                  else               chk(rsp_code == e_rsp, "R10 toggle", rsp_code, e_rsp);
                  chk(exp_pid == e_tog[0], "R10 exp_pid track", exp_pid, e_tog);
               end
               // R1 stall overrides
               wr_csr(word(en[0], k, b[0], 1, 0));
               send(1'b0);
               chk(rsp_code == 1, "R1 stall resp", rsp_code, 1);
               send(1'b1);
               chk(rsp_code == 1, "R1 stall resp", rsp_code, 1);
               chk(exp_pid == e_tog[0], "R1 toggle kept", exp_pid, e_tog);
               wr_csr(word(en[0], k, b[0], 0, 0));
               chk(stall_active == 0, "R1 stall cleared", stall_active, 0);
            end

      // R2 R12: setup on control endpoint
      wr_csr(word(1, 0, 0, 1, 1));
      chk(stall_active == 1, "R1 stall set", stall_active, 1);
      pulse_setup();
      chk(stall_active == 0, "R2 setup clears stall", stall_active, 0);
      chk(exp_pid == 1, "R12 setup DATA1", exp_pid, 1);
      // R2 non-control: no effect
      wr_csr(word(1, 2, 0, 1, 1));
      pulse_setup();
      chk(stall_active == 1, "R2 bulk keeps stall", stall_active, 1);
      chk(exp_pid == 0, "R12 bulk no DATA1", exp_pid, 0);

      // R3 setup_stat window
      wr_csr(word(1, 0, 0, 0, 0));
      setup_stat = 1'b1;
      @(negedge clk);
      wr_csr(word(1, 0, 0, 1, 0));
      chk(stall_active == 0, "R3 write lost", stall_active, 0);
      wr_csr(word(1, 0, 0, 1, 0));
      chk(stall_active == 0, "R3 write lost again", stall_active, 0);

      // R4 holdoff after drop
      setup_stat = 1'b0;
      repeat (HO - 1) @(negedge clk);
      csr_wr = 1'b1; csr_wdata = word(1, 0, 0, 1, 0);
      @(negedge clk);
      chk(stall_active == 0, "R4 last blocked edge", stall_active, 0);
      @(negedge clk);
      csr_wr = 1'b0; csr_wdata = '0;
      chk(stall_active == 1, "R4 first free edge", stall_active, 1);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule